// File: doc/BRIEF.md
# Masked Template Screen for Binary Pixel Windows

This block decides whether a small binary image neighbourhood is acceptable. A stream of 5x5 windows is fed in, one window per clock. Each window is flattened into a 25-bit key. Pixel (row r, column c) sits at key bit r*5+c. The key is compared at the same moment against every entry of a small programmable store. Each entry holds a pattern, a care mask and a valid flag. Bits whose care bit is clear are not compared, so one entry can stand for a whole family of allowed shapes.

The store is meant to hold only the shapes that are allowed. A window that matches at least one valid entry is therefore accepted. A window that matches none is reported as a defect, so the interesting answer is a miss. Entries are loaded through a write port that runs alongside the lookup stream and never stalls it. Each result appears one cycle after its key. The result carries the verdict, a hit flag and the index of the lowest-numbered matching entry.

Top module: `tcam_screen`

## Requirements
- R1: After reset every entry is invalid, so every lookup made before the first write with the valid flag set reports a defect.
- R2: `res_valid` is high in the cycle after the cycle in which `key_valid` was high, and low after a cycle in which `key_valid` was low.
- R3: An entry matches a key when, for every bit position whose care bit is 1, the key bit equals the stored pattern bit. Bits whose care bit is 0 are ignored. A single differing cared-for bit prevents the match.
- R4: An entry whose valid flag is 0 never matches, whatever its pattern and mask.
- R5: When `res_valid` is high, `res_hit` is 1 if at least one valid entry matched the key, and `res_defect` is the inverse of `res_hit`.
- R6: On a hit, `res_index` gives the lowest-numbered matching entry. On a miss, `res_index` is 0.
- R7: A valid entry whose care mask is all zeros matches every key.
- R8: A write takes effect for lookups in later cycles. A lookup made in the same cycle as a write sees the store as it was before that write.
- R9: Lookups can be presented in every cycle, back to back, and each one gets its own result one cycle later.
- R10: While `res_valid` is low, `res_hit` and `res_defect` are 0 and `res_index` is 0. All outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one store entry this cycle |
| wr_idx | input | 5 | Entry number to write |
| wr_value | input | 25 | Pattern bits for the entry |
| wr_care | input | 25 | Care mask; 1 means the bit is compared |
| wr_valid | input | 1 | Valid flag stored with the entry |
| key_valid | input | 1 | A window key is presented this cycle |
| key | input | 25 | Flattened window, pixel (r,c) at bit r*5+c |
| res_valid | output | 1 | Result for the key of the previous cycle |
| res_defect | output | 1 | No valid entry matched |
| res_hit | output | 1 | At least one valid entry matched |
| res_index | output | 5 | Lowest matching entry, 0 on a miss |

## Verification
The assertions assume that reset is applied before use and that every control input carries a defined level on each clock edge. They treat a write with the valid flag set as the only event that can make a hit possible, so the empty-store check keys off that. The bench changes all inputs on the falling edge. It draws entry numbers only inside the store's range and keeps the write controls at known values in every cycle, including idle ones.

// File: rtl/tcam_screen_pkg.sv
package tcam_screen_pkg;

   // Selects how a single entry is compared against the key
   typedef enum int {
      CMP_BITWISE = 0,   // per-bit agreement, then AND-reduce
      CMP_MASKEQ  = 1    // masked equality of two vectors
   } cmp_style_e;

   localparam int unsigned WIN_DIM_DEFAULT = 5;
   localparam int unsigned ENTRIES_DEFAULT = 32;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tcam_screen_store.sv
module tcam_screen_store #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned KEY_W   = 25,
   parameter int unsigned IDX_W   = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [KEY_W-1:0]                 wr_value,
   input  logic [KEY_W-1:0]                 wr_care,
   input  logic                             wr_valid,
   output logic [ENTRIES-1:0][KEY_W-1:0]    ent_value,
   output logic [ENTRIES-1:0][KEY_W-1:0]    ent_care,
   output logic [ENTRIES-1:0]               ent_valid
);

   logic [ENTRIES-1:0] sel;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      assign sel[e] = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_value[e] <= '0;
            ent_care[e]  <= '0;
            ent_valid[e] <= 1'b0;
         end else if (sel[e]) begin
            ent_value[e] <= wr_value;
            ent_care[e]  <= wr_care;
            ent_valid[e] <= wr_valid;
         end
      end
   end

endmodule

// File: rtl/tcam_screen_compare.sv
module tcam_screen_compare
   import tcam_screen_pkg::*;
#(
   parameter int unsigned ENTRIES   = 32,
   parameter int unsigned KEY_W     = 25,
   parameter cmp_style_e  CMP_STYLE = CMP_BITWISE
) (
   input  logic [KEY_W-1:0]              key,
   input  logic [ENTRIES-1:0][KEY_W-1:0] ent_value,
   input  logic [ENTRIES-1:0][KEY_W-1:0] ent_care,
   input  logic [ENTRIES-1:0]            ent_valid,
   output logic [ENTRIES-1:0]            match_vec
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic agree;
      if (CMP_STYLE == CMP_BITWISE) begin : g_bitwise
         logic [KEY_W-1:0] bit_ok;
         for (genvar b = 0; b < KEY_W; b++) begin : g_bit
            assign bit_ok[b] = !ent_care[e][b] || (key[b] == ent_value[e][b]);
         end
         assign agree = &bit_ok;
      end else begin : g_maskeq
         assign agree = ((key ^ ent_value[e]) & ent_care[e]) == '0;
      end
      assign match_vec[e] = ent_valid[e] && agree;
   end

endmodule

// File: rtl/tcam_screen_prio.sv
module tcam_screen_prio #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned IDX_W   = 5
) (
   input  logic [ENTRIES-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   first
);

   always_comb begin
      first = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (req[i]) first = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/tcam_screen.sv
module tcam_screen
   import tcam_screen_pkg::*;
#(
   parameter int unsigned WIN_DIM   = WIN_DIM_DEFAULT,
   parameter int unsigned ENTRIES   = ENTRIES_DEFAULT,
   parameter cmp_style_e  CMP_STYLE = CMP_BITWISE,
   parameter int unsigned KEY_W     = WIN_DIM * WIN_DIM,
   parameter int unsigned IDX_W     = idx_bits(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [KEY_W-1:0] wr_value,
   input  logic [KEY_W-1:0] wr_care,
   input  logic             wr_valid,
   input  logic             key_valid,
   input  logic [KEY_W-1:0] key,
   output logic             res_valid,
   output logic             res_defect,
   output logic             res_hit,
   output logic [IDX_W-1:0] res_index
);

   // Elaboration-time parameter checks
   if (WIN_DIM < 1 || WIN_DIM > 8) begin : g_bad_dim
      $error("tcam_screen: WIN_DIM out of range");
   end
   if (KEY_W != WIN_DIM * WIN_DIM) begin : g_bad_key
      $error("tcam_screen: KEY_W must equal WIN_DIM squared");
   end
   if (ENTRIES < 1 || ENTRIES > 256) begin : g_bad_depth
      $error("tcam_screen: ENTRIES out of range");
   end
   if ((1 << IDX_W) < ENTRIES) begin : g_bad_idx
      $error("tcam_screen: IDX_W too narrow for ENTRIES");
   end

   logic [ENTRIES-1:0][KEY_W-1:0] ent_value;
   logic [ENTRIES-1:0][KEY_W-1:0] ent_care;
   logic [ENTRIES-1:0]            ent_valid;
   logic [ENTRIES-1:0]            match_vec;
   logic                          any_hit;
   logic [IDX_W-1:0]              first_idx;

   tcam_screen_store #(
      .ENTRIES (ENTRIES),
      .KEY_W   (KEY_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_value  (wr_value),
      .wr_care   (wr_care),
      .wr_valid  (wr_valid),
      .ent_value (ent_value),
      .ent_care  (ent_care),
      .ent_valid (ent_valid)
   );

   tcam_screen_compare #(
      .ENTRIES   (ENTRIES),
      .KEY_W     (KEY_W),
      .CMP_STYLE (CMP_STYLE)
   ) u_compare (
      .key       (key),
      .ent_value (ent_value),
      .ent_care  (ent_care),
      .ent_valid (ent_valid),
      .match_vec (match_vec)
   );

   tcam_screen_prio #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_prio (
      .req   (match_vec),
      .any   (any_hit),
      .first (first_idx)
   );

   // Result register: one cycle from key to verdict
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_defect <= 1'b0;
         res_hit    <= 1'b0;
         res_index  <= '0;
      end else begin
         res_valid <= key_valid;
         if (key_valid) begin
            res_hit    <= any_hit;
            res_defect <= !any_hit;
            res_index  <= any_hit ? first_idx : '0;
         end else begin
            res_hit    <= 1'b0;
            res_defect <= 1'b0;
            res_index  <= '0;
         end
      end
   end

endmodule

// File: rtl/tcam_screen_chk.sv
module tcam_screen_chk #(
   parameter int unsigned IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_valid,
   input logic             key_valid,
   input logic             res_valid,
   input logic             res_defect,
   input logic             res_hit,
   input logic [IDX_W-1:0] res_index
);

   // Set once any entry has been written with its valid flag high
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n)                  armed <= 1'b0;
      else if (wr_en && wr_valid)  armed <= 1'b1;
   end

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> res_valid);

   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !key_valid |=> !res_valid);

   a_r5_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_defect != res_hit));

   a_r6_miss_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_index == '0));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_hit && !res_defect && res_index == '0));

   a_r1_empty_store_defect: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(armed)) |-> res_defect);

endmodule

bind tcam_screen tcam_screen_chk #(.IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_valid   (wr_valid),
   .key_valid  (key_valid),
   .res_valid  (res_valid),
   .res_defect (res_defect),
   .res_hit    (res_hit),
   .res_index  (res_index)
);

// File: tb/tcam_screen_test.sv
module tcam_screen_test;

   localparam int CLK_PERIOD = 10;
   localparam int KW = 25;
   localparam int NE = 32;
   localparam int IW = 5;
   localparam logic [KW-1:0] ALL1 = {KW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [KW-1:0] wr_value = '0;
   logic [KW-1:0] wr_care = '0;
   logic          wr_valid = 1'b0;
   logic          key_valid = 1'b0;
   logic [KW-1:0] key = '0;
   logic          res_valid, res_defect, res_hit;
   logic [IW-1:0] res_index;

   tcam_screen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_value(wr_value), .wr_care(wr_care), .wr_valid(wr_valid),
      .key_valid(key_valid), .key(key), .res_valid(res_valid),
      .res_defect(res_defect), .res_hit(res_hit), .res_index(res_index)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Reference store
   logic [KW-1:0] m_val  [NE];
   logic [KW-1:0] m_care [NE];
   logic          m_vld  [NE];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Expectation for the result that appears after the next edge
   bit            p_v = 1'b0;
   bit            p_hit = 1'b0;
   int            p_idx = 0;
   string         p_tag = "R2";

   function automatic int ref_lookup(input logic [KW-1:0] k);
      for (int e = 0; e < NE; e++) begin
         if (m_vld[e] && (((k ^ m_val[e]) & m_care[e]) == '0)) return e;
      end
      return -1;
   endfunction

   task automatic chk(input string tag, input bit ok, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // One cycle: check the previous result, then drive this cycle's inputs
   task automatic step(input bit we, input int widx, input logic [KW-1:0] wv,
                       input logic [KW-1:0] wc, input bit wvl,
                       input bit kv, input logic [KW-1:0] k, input string tag);
      int r;
      @(negedge clk);
      chk(p_tag, res_valid == p_v, "res_valid", res_valid, p_v);
      if (p_v) begin
         chk(p_tag, res_hit == p_hit, "res_hit", res_hit, p_hit);
         chk(p_tag, res_defect == !p_hit, "res_defect", res_defect, !p_hit);
         chk(p_tag, int'(res_index) == (p_hit ? p_idx : 0), "res_index",
             res_index, p_hit ? p_idx : 0);
      end else begin
         chk("R10", !res_hit && !res_defect && res_index == 0, "idle outputs",
             {res_hit, res_defect, res_index}, 0);
      end
      wr_en = we; wr_idx = IW'(widx); wr_value = wv; wr_care = wc; wr_valid = wvl;
      key_valid = kv; key = k;
      // expectation uses the store before this cycle's write (R8)
      r = ref_lookup(k);
      p_v = kv; p_hit = (r >= 0); p_idx = (r >= 0) ? r : 0; p_tag = tag;
      if (we) begin
         m_val[widx] = wv; m_care[widx] = wc; m_vld[widx] = wvl;
      end
   endtask

   task automatic look(input logic [KW-1:0] k, input string tag);
      step(1'b0, 0, '0, '0, 1'b0, 1'b1, k, tag);
   endtask

   task automatic wr(input int idx, input logic [KW-1:0] v, input logic [KW-1:0] c,
                     input bit vl);
      step(1'b1, idx, v, c, vl, 1'b0, '0, "R2");
   endtask

   function automatic logic [KW-1:0] rnd_key();
      return KW'($urandom);
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   localparam logic [KW-1:0] PAT = 25'h0A5_3C1;

   initial begin
      void'($urandom(32'd20240611));
      for (int e = 0; e < NE; e++) begin
         m_val[e] = '0; m_care[e] = '0; m_vld[e] = 1'b0;
      end
      // R10: outputs held low during reset
      repeat (3) @(negedge clk);
      chk("R10", {res_valid, res_hit, res_defect, res_index} == 0, "reset outputs",
          {res_valid, res_hit, res_defect, res_index}, 0);
      rst_n = 1'b1;

      // R1: empty store flags everything, including an all-ones and all-zeros key
      look('0, "R1");
      look(ALL1, "R1");
      look(PAT, "R1");
      step(1'b0, 0, '0, '0, 1'b0, 1'b0, '0, "R2");

      // R3: exact entry, then a single cared-for bit flipped
      wr(5, PAT, ALL1, 1'b1);
      look(PAT, "R3");
      look(PAT ^ (25'd1 << 7), "R3");
      look(PAT ^ (25'd1 << 24), "R3");
      // R3: clear care on bit 7, the flipped key now matches
      wr(5, PAT, ALL1 & ~(25'd1 << 7), 1'b1);
      look(PAT ^ (25'd1 << 7), "R3");
      look(PAT ^ (25'd1 << 8), "R3");

      // R8: invalidate entry 5 in the same cycle as a lookup of PAT
      step(1'b1, 5, PAT, ALL1, 1'b0, 1'b1, PAT, "R8");
      look(PAT, "R8");

      // R4: invalid entry with an empty mask never matches
      wr(9, '0, '0, 1'b0);
      look(rnd_key(), "R4");
      look('0, "R4");

      // R7: a valid all-don't-care entry matches every key
      wr(20, PAT, '0, 1'b1);
      look(rnd_key(), "R7");
      look(ALL1, "R7");
      look('0, "R7");

      // R6: lower entry wins when two match
      wr(3, PAT, ALL1, 1'b1);
      look(PAT, "R6");
      look(PAT ^ 25'd1, "R6");
      wr(0, ~PAT, ALL1, 1'b1);
      look(~PAT, "R6");
      wr(20, '0, '0, 1'b0);
      wr(31, ~PAT, ALL1, 1'b1);
      look(~PAT, "R6");
      wr(0, '0, '0, 1'b0);
      look(~PAT, "R6");

      // R2, R10: gaps between lookups
      step(1'b0, 0, '0, '0, 1'b0, 1'b0, '0, "R2");
      look(PAT, "R2");
      step(1'b0, 0, '0, '0, 1'b0, 1'b0, PAT, "R10");

      // Random fill of the store
      for (int e = 0; e < NE; e++) begin
         wr(e, rnd_key(), KW'($urandom | $urandom | $urandom), ($urandom % 8) != 0);
      end

      // R5, R9: back-to-back random lookups with occasional writes
      for (int n = 0; n < 3000; n++) begin
         logic [KW-1:0] k;
         int j;
         j = $urandom % NE;
         if ($urandom % 2 == 0) k = (m_val[j] & m_care[j]) | (rnd_key() & ~m_care[j]);
         else                   k = rnd_key();
         if ($urandom % 10 == 0)
            step(1'b1, $urandom % NE, rnd_key(),
                 ($urandom % 16 == 0) ? '0 : KW'($urandom | $urandom | $urandom),
                 ($urandom % 6) != 0, 1'b1, k, "R9");
         else
            step(1'b0, 0, '0, '0, 1'b0, ($urandom % 12) != 0, k, "R5");
      end
      step(1'b0, 0, '0, '0, 1'b0, 1'b0, '0, "R2");
      step(1'b0, 0, '0, '0, 1'b0, 1'b0, '0, "R2");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule